// File: doc/BRIEF.md
# Sector Test Pattern Generator and Checker

This block exercises the 128-bit data path of a file-storage engine through its two FIFOs. A write-file command starts a bounded stream of generated beats into the write FIFO. The stream pauses whenever that FIFO reports almost-full and stops on its own once it has produced file count times file size bytes. In read mode the block drains the read FIFO whenever it is not empty. It regenerates the beat it expects at the current position and compares the two. The first disagreement is latched for later inspection.

Data is organised in 512-byte sectors of 32 beats. Three of the patterns place a 64-bit sector-address header at the front of each sector. The header address is the first file index scaled by the decoded file size, plus the sector index within the transfer. Because the file size in sectors is always a power of two, the file index and the byte offset of a failure come from shifting one running byte counter. The same counter is exposed as the current transfer size.

Top module: `fifo_pattern_engine`

## Requirements
- R1: After reset, wr_en, rd_en, wr_busy and fail are 0 and xfer_bytes is 0.
- R2: A start pulse with dir_read=0 and file_count nonzero sets wr_busy in the following cycle. While wr_busy is 1, wr_en equals NOT wr_afull.
- R3: While wr_afull is 1, no beat is written and xfer_bytes holds its value.
- R4: The file size in sectors is 2^(size_code) with default parameters. Once file_count*2^(size_code)*512 bytes have been written, wr_busy and wr_en fall together. A write start with file_count 0 never raises wr_busy.
- R5: For patterns 000, 001 and 100, the beat at each byte position that is a multiple of 512 carries a header. Bits [47:0] hold first_file*2^(size_code) + (byte position / 512), and bits [63:48] are zero.
- R6: Pattern 000 places (byte position/4 + i) mod 2^32 in dword lane i, bits [32i+31:32i], for i = 0 to 3. Pattern 001 places the bitwise NOT of that value.
- R7: Pattern 010 produces all-zero beats and pattern 011 produces all-one beats, neither with a header. Codes 101, 110 and 111 also produce zeros with no header.
- R8: Pattern 100 uses a 32-bit LFSR seeded with 0x00000001 and stepped as s -> {s[30:0], s[31]^s[21]^s[1]}. Lane i holds the state advanced i steps, and each transferred beat advances the register by four steps.
- R9: rd_en equals NOT rd_empty whenever the last start chose read mode (dir_read=1). rd_en has no length limit, and it stays 0 in write mode. rd_data is taken in the same cycle that rd_en is 1.
- R10: A read beat that differs from the expected beat sets fail, which stays set. The expected and read words, the byte offset within the file and the file index (first_file + position / file bytes) of the first mismatch are latched, and later mismatches leave them unchanged.
- R11: xfer_bytes advances by 16 for every beat written or read.
- R12: A start clears xfer_bytes, fail and the capture registers, and reloads the LFSR seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command start pulse |
| dir_read | input | 1 | 1 selects read-and-check mode, 0 selects write mode |
| first_file | input | FILE_W | Index of the first file |
| file_count | input | FILE_W | Number of files to transfer |
| size_code | input | 3 | File size code (log2 sectors step) |
| patt_sel | input | 3 | Pattern select |
| wr_afull | input | 1 | Write FIFO almost full |
| wr_en | output | 1 | Write FIFO write enable |
| wr_data | output | 128 | Generated beat |
| rd_empty | input | 1 | Read FIFO empty |
| rd_en | output | 1 | Read FIFO read enable |
| rd_data | input | 128 | Read FIFO output, valid with rd_en |
| wr_busy | output | 1 | Write transfer active |
| xfer_bytes | output | CNT_W | Bytes transferred since start |
| fail | output | 1 | Sticky mismatch flag |
| fail_exp | output | 128 | Expected beat at first mismatch |
| fail_got | output | 128 | Read beat at first mismatch |
| fail_offset | output | CNT_W | Byte offset within the file of first mismatch |
| fail_file | output | FILE_W | File index of first mismatch |

## Verification
The hardest situation to reach is a first mismatch that must survive later ones while the read FIFO keeps stalling. The capture must name the right file and offset even though the failing beat arrives after an irregular run of empty cycles. The bench corrupts two chosen beats of a multi-file LFSR read and drives rd_empty randomly from a fixed seed. It then compares the captured words, offset and file index with the first corrupted position tracked by its own model. Random write runs with random almost-full stalls cover pauses that land on sector and file boundaries.

// File: rtl/fifo_pattern_engine.sv
module fifo_pattern_engine #(
  parameter int          FILE_W    = 27,
  parameter int          CNT_W     = 57,
  parameter int          SIZE_BASE = 0,
  parameter int          SIZE_STEP = 1,
  parameter logic [31:0] LFSR_SEED = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_read,
  input  logic [FILE_W-1:0] first_file,
  input  logic [FILE_W-1:0] file_count,
  input  logic [2:0]        size_code,
  input  logic [2:0]        patt_sel,
  input  logic              wr_afull,
  output logic              wr_en,
  output logic [127:0]      wr_data,
  input  logic              rd_empty,
  output logic              rd_en,
  input  logic [127:0]      rd_data,
  output logic              wr_busy,
  output logic [CNT_W-1:0]  xfer_bytes,
  output logic              fail,
  output logic [127:0]      fail_exp,
  output logic [127:0]      fail_got,
  output logic [CNT_W-1:0]  fail_offset,
  output logic [FILE_W-1:0] fail_file
);

  localparam int LANES = 4;
  localparam int HDR_W = 48;
  localparam logic [CNT_W-1:0] BEAT_BYTES = CNT_W'(16);

  function automatic logic [31:0] lstep(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1]};
  endfunction

  function automatic logic [5:0] sec_shift(input logic [2:0] c);
    return 6'(SIZE_BASE) + 6'(c) * 6'(SIZE_STEP);
  endfunction

  logic              busy_q, read_q;
  logic [2:0]        sel_q, code_q;
  logic [FILE_W-1:0] first_q, count_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       lfsr_q, lfsr_nxt;
  logic [127:0]      beat;

  wire [5:0]       fshift  = sec_shift(code_q) + 6'd9;
  wire [CNT_W-1:0] total_q = CNT_W'(count_q) << fshift;
  wire [HDR_W-1:0] sec_adr = (HDR_W'(first_q) << sec_shift(code_q)) + HDR_W'(cnt_q >> 9);
  wire             hdr_on  = (sel_q == 3'b000 || sel_q == 3'b001 || sel_q == 3'b100)
                             && cnt_q[8:0] == 9'd0;

  always_comb begin
    logic [31:0] lf;
    logic [31:0] dw;
    lf = lfsr_q;
    for (int i = 0; i < LANES; i++) begin
      dw = cnt_q[33:2] + 32'(i);
      case (sel_q)
        3'b000:  beat[32*i +: 32] = dw;
        3'b001:  beat[32*i +: 32] = ~dw;
        3'b011:  beat[32*i +: 32] = '1;
        3'b100:  beat[32*i +: 32] = lf;
        default: beat[32*i +: 32] = '0;
      endcase
      lf = lstep(lf);
    end
    lfsr_nxt = lf;
    if (hdr_on) beat[63:0] = {16'h0, sec_adr};
  end

  assign wr_en      = busy_q & ~read_q & ~wr_afull;
  assign rd_en      = read_q & ~rd_empty;
  assign wr_data    = beat;
  assign wr_busy    = busy_q;
  assign xfer_bytes = cnt_q;
  wire   mismatch   = rd_en && (rd_data != beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; read_q <= 1'b0; sel_q <= '0; code_q <= '0;
      first_q <= '0; count_q <= '0; cnt_q <= '0; lfsr_q <= LFSR_SEED;
      fail <= 1'b0; fail_exp <= '0; fail_got <= '0; fail_offset <= '0; fail_file <= '0;
    end else if (start) begin
      read_q  <= dir_read;
      busy_q  <= !dir_read && file_count != '0;
      sel_q   <= patt_sel;
      code_q  <= size_code;
      first_q <= first_file;
      count_q <= file_count;
      cnt_q   <= '0;
      lfsr_q  <= LFSR_SEED;
      fail <= 1'b0; fail_exp <= '0; fail_got <= '0; fail_offset <= '0; fail_file <= '0;
    end else begin
      if (wr_en || rd_en) begin
        cnt_q  <= cnt_q + BEAT_BYTES;
        lfsr_q <= lfsr_nxt;
      end
      if (wr_en && cnt_q + BEAT_BYTES == total_q) busy_q <= 1'b0;
      if (mismatch && !fail) begin
        fail        <= 1'b1;
        fail_exp    <= beat;
        fail_got    <= rd_data;
        fail_offset <= cnt_q & ((CNT_W'(1) << fshift) - CNT_W'(1));
        fail_file   <= first_q + FILE_W'(cnt_q >> fshift);
      end
    end
  end

  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dir_read && file_count != '0) |=> wr_busy && xfer_bytes == '0); // R2
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en && !start) |=> $stable(xfer_bytes)); // R3
  AST_WRITE_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_busy) && !$past(start)) |-> xfer_bytes == total_q); // R4
  AST_READ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !rd_empty && !wr_en); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail && $stable(fail_got) && $stable(fail_exp)); // R10
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && !start) |=> xfer_bytes == CNT_W'($past(xfer_bytes) + BEAT_BYTES)); // R11
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> xfer_bytes == '0 && !fail); // R12

endmodule

// File: tb/fifo_pattern_engine_tb.sv
module fifo_pattern_engine_tb;
  localparam int FILE_W = 27;
  localparam int CNT_W  = 57;
  localparam logic [31:0] SEED = 32'h0000_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, dir_read = 0, wr_afull = 0, rd_empty = 1;
  logic [FILE_W-1:0] first_file = '0, file_count = '0;
  logic [2:0] size_code = '0, patt_sel = '0;
  logic [127:0] rd_data = '0;
  logic wr_en, rd_en, wr_busy, fail;
  logic [127:0] wr_data, fail_exp, fail_got;
  logic [CNT_W-1:0] xfer_bytes, fail_offset;
  logic [FILE_W-1:0] fail_file;

  int checks = 0, errors = 0;
  logic [CNT_W-1:0] m_pos;
  logic [31:0] m_lfsr;

  always #10 clk = ~clk;

  fifo_pattern_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_read(dir_read),
    .first_file(first_file), .file_count(file_count), .size_code(size_code),
    .patt_sel(patt_sel), .wr_afull(wr_afull), .wr_en(wr_en), .wr_data(wr_data),
    .rd_empty(rd_empty), .rd_en(rd_en), .rd_data(rd_data), .wr_busy(wr_busy),
    .xfer_bytes(xfer_bytes), .fail(fail), .fail_exp(fail_exp), .fail_got(fail_got),
    .fail_offset(fail_offset), .fail_file(fail_file));

  function automatic logic [31:0] lstep(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1]};
  endfunction

  function automatic logic [127:0] exp_beat(input int sel, input logic [CNT_W-1:0] pos,
                                            input int first, input int code, input logic [31:0] lf);
    logic [127:0] b;
    logic [31:0] l, d;
    logic [47:0] adr;
    l = lf;
    d = pos[33:2];
    for (int i = 0; i < 4; i++) begin
      case (sel)
        0: b[32*i +: 32] = d + 32'(i);
        1: b[32*i +: 32] = ~(d + 32'(i));
        3: b[32*i +: 32] = 32'hFFFF_FFFF;
        4: b[32*i +: 32] = l;
        default: b[32*i +: 32] = 32'h0;
      endcase
      l = lstep(l);
    end
    if ((sel == 0 || sel == 1 || sel == 4) && pos[8:0] == 9'd0) begin
      adr = (48'(first) << code) + 48'(pos >> 9);
      b[63:0] = {16'h0, adr};
    end
    return b;
  endfunction

  function automatic logic [31:0] adv4(input logic [31:0] s);
    return lstep(lstep(lstep(lstep(s))));
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string data_tag(input int sel, input logic [CNT_W-1:0] pos);
    if ((sel == 0 || sel == 1 || sel == 4) && pos[8:0] == 9'd0) return "R5";
    if (sel == 0 || sel == 1) return "R6";
    if (sel == 4) return "R8";
    return "R7";
  endfunction

  task automatic do_start(input bit rd, input int first, input int cnt, input int code, input int sel);
    @(negedge clk);
    dir_read = rd; first_file = FILE_W'(first); file_count = FILE_W'(cnt);
    size_code = 3'(code); patt_sel = 3'(sel); start = 1;
    wr_afull = 0; rd_empty = 1;
    @(negedge clk);
    start = 0;
    m_pos = '0;
    m_lfsr = SEED;
  endtask

  task automatic run_write(input int first, input int cnt, input int code, input int sel, input int afp);
    logic [CNT_W-1:0] total;
    int guard;
    total = CNT_W'(cnt) << (code + 9);
    do_start(0, first, cnt, code, sel);
    check(wr_busy == (cnt != 0), "R2 busy after start", 128'(wr_busy), 128'(cnt != 0));
    check(xfer_bytes == '0, "R12 count cleared", 128'(xfer_bytes), 0);
    guard = 0;
    while (wr_busy && guard < 20000) begin
      wr_afull = ($urandom % 100) < afp;
      rd_empty = 0;
      #1;
      check(wr_en == !wr_afull, wr_afull ? "R3 stall" : "R2 enable", 128'(wr_en), 128'(!wr_afull));
      check(rd_en == 0, "R9 no read in write mode", 128'(rd_en), 0);
      check(xfer_bytes == m_pos, "R11 byte count", 128'(xfer_bytes), 128'(m_pos));
      if (wr_en) begin
        check(wr_data == exp_beat(sel, m_pos, first, code, m_lfsr), data_tag(sel, m_pos),
              wr_data, exp_beat(sel, m_pos, first, code, m_lfsr));
        m_pos = m_pos + 16;
        m_lfsr = adv4(m_lfsr);
      end
      @(negedge clk);
      guard++;
    end
    wr_afull = 0;
    #1;
    check(m_pos == total, "R4 beats written", 128'(m_pos), 128'(total));
    check(xfer_bytes == total, "R11 final count", 128'(xfer_bytes), 128'(total));
    check(wr_en == 0 && wr_busy == 0, "R4 stopped", 128'({wr_en, wr_busy}), 0);
  endtask

  task automatic run_read(input int first, input int cnt, input int code, input int sel,
                          input int c1, input int c2, input int extra);
    int beats, guard, hit;
    logic [127:0] e, cap_e, cap_g;
    logic [CNT_W-1:0] cap_pos;
    beats = (cnt << (code + 9)) / 16 + extra;
    hit = 0; cap_e = '0; cap_g = '0; cap_pos = '0;
    do_start(1, first, cnt, code, sel);
    guard = 0;
    while (int'(m_pos / 16) < beats && guard < 20000) begin
      rd_empty = ($urandom % 100) < 35;
      e = exp_beat(sel, m_pos, first, code, m_lfsr);
      rd_data = e;
      if (int'(m_pos / 16) == c1 || int'(m_pos / 16) == c2) rd_data = e ^ (128'h1 << 37);
      #1;
      check(rd_en == !rd_empty, "R9 read follows not-empty", 128'(rd_en), 128'(!rd_empty));
      if (rd_en) begin
        if (rd_data != e && !hit) begin
          hit = 1; cap_e = e; cap_g = rd_data; cap_pos = m_pos;
        end
        m_pos = m_pos + 16;
        m_lfsr = adv4(m_lfsr);
      end
      @(negedge clk);
      guard++;
    end
    rd_empty = 1;
    #1;
    check(xfer_bytes == m_pos, "R11 read count", 128'(xfer_bytes), 128'(m_pos));
    check(fail == hit[0], "R10 fail flag", 128'(fail), 128'(hit));
    if (hit) begin
      check(fail_exp == cap_e, "R10 expected word", fail_exp, cap_e);
      check(fail_got == cap_g, "R10 read word", fail_got, cap_g);
      check(fail_offset == (cap_pos & ((CNT_W'(1) << (code + 9)) - 1)), "R10 offset",
            128'(fail_offset), 128'(cap_pos & ((CNT_W'(1) << (code + 9)) - 1)));
      check(fail_file == FILE_W'(first) + FILE_W'(cap_pos >> (code + 9)), "R10 file index",
            128'(fail_file), 128'(FILE_W'(first) + FILE_W'(cap_pos >> (code + 9))));
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_empty = 0;
    #1;
    check(wr_en == 0 && rd_en == 0 && wr_busy == 0 && fail == 0 && xfer_bytes == '0,
          "R1 reset state", 128'({wr_en, rd_en, wr_busy, fail, xfer_bytes}), 0);

    run_write(3, 2, 1, 0, 30);
    run_write(5, 1, 2, 1, 50);
    run_write(9, 2, 0, 2, 20);
    run_write(1, 1, 1, 3, 20);
    run_write(7, 3, 1, 4, 40);
    run_write(2, 1, 0, 5, 10);
    run_write(4, 0, 2, 0, 0);
    for (int k = 0; k < 4; k++)
      run_write($urandom % 1000, 1 + $urandom % 3, $urandom % 3, $urandom % 8, 30);

    run_read(0, 2, 1, 0, -1, -1, 10);
    run_read(6, 3, 1, 4, 70, 90, 0);
    do_start(1, 0, 1, 0, 0);
    #1;
    check(fail == 0 && xfer_bytes == '0 && fail_got == '0, "R12 start clears fail",
          128'({fail, xfer_bytes}), 0);
    run_write(2, 1, 0, 4, 25);  // R12 first LFSR beats start again from the seed
    run_read(11, 2, 0, 1, 40, -1, 0);

    $display("%0d/%0d checks passed", checks - errors, checks);
    $finish;
  end
endmodule